// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns characters written into a small transmit buffer into frames on a single serial line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. Each bit lasts exactly one period of an external baud tick, which pulses for one clock cycle per bit time. The line idles high. Frames follow each other with no gap while characters are queued.

The frame format comes from static line-control inputs. They are sampled when a frame starts, so the format of a frame cannot change while it is on the line. The format covers the data width, the parity (odd, even or a constant stick value), the number of stop bits, and whether the buffer runs as a 16-entry queue or as a single holding register. A transmit enable, a break request and clear-to-send flow control decide whether a new frame may begin. None of them cuts a frame short: the character on the line always finishes. Busy, buffer-empty and buffer-full flags report progress to the host logic that owns the buffer.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `buf_empty` is 1 and `buf_full` is 0.
- R2: A frame starts on a `baud_tick` cycle. It is a 0 start bit, then the data bits least significant first, then the parity bit when enabled, then the stop bits at 1. Every bit holds for one tick period. A queued character starts directly after the last stop bit of the previous frame.
- R3: `word_len` selects the number of data bits: 2'b11 gives 8, 2'b10 gives 7, 2'b01 gives 6 and 2'b00 gives 5. The unused upper bits of the written character are not sent.
- R4: With `par_en`=1 and `stick_par`=0, the parity bit makes the number of ones across the data and parity bits odd when `even_sel`=0 and even when `even_sel`=1. With `par_en`=0 no parity bit is sent.
- R5: With `par_en`=1 and `stick_par`=1, the parity bit is 1 when `even_sel`=0 and 0 when `even_sel`=1.
- R6: `two_stop`=1 ends each frame with two stop bits; `two_stop`=0 ends it with one.
- R7: While `send_break`=1, the character in progress completes, then `txd` is held at 0 and no new frame starts. Releasing the break returns `txd` to 1.
- R8: Clearing `tx_enable` mid-frame lets the current frame complete. No new frame starts while `tx_enable`=0.
- R9: `busy` is 1 in the cycle after a write is accepted, even with `tx_enable`=0. It stays 1 until the last stop bit of the last queued character has ended.
- R10: `buf_empty` shows only the buffer. It goes to 1 when the last queued character moves to the shift register at the start of its frame, while `busy` stays 1.
- R11: With `cts_flow_en`=1 a new frame starts only while `cts`=1. With `cts_flow_en`=0, `cts` has no effect.
- R12: With `fifo_mode`=1 the buffer holds 16 characters; with `fifo_mode`=0 it holds 1. `buf_full` is 1 at capacity, and a write while the buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write one character into the buffer |
| wr_data | input | 8 | Character to write |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| word_len | input | 2 | Data width code |
| par_en | input | 1 | Parity bit enable |
| even_sel | input | 1 | Even parity select |
| stick_par | input | 1 | Constant (stick) parity select |
| two_stop | input | 1 | Two stop bits select |
| send_break | input | 1 | Hold the line low after the current frame |
| tx_enable | input | 1 | Allow new frames to start |
| cts_flow_en | input | 1 | Gate frame starts on `cts` |
| cts | input | 1 | Clear to send, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output, idle high |
| busy | output | 1 | Buffer non-empty or frame on the line |
| buf_empty | output | 1 | Buffer holds no character |
| buf_full | output | 1 | Buffer at capacity |

## Verification
The bench builds the block with its default 16-entry buffer and drives a baud tick every four clocks. With so short a bit, it can sweep all 64 combinations of word length, parity enable, even select, stick parity and stop count. For each combination it decodes two back-to-back frames and checks the data, the parity and the exact spacing between start edges. The 16-entry depth makes the full flag and the dropped seventeenth write reachable within a few hundred cycles. The single-register mode, mid-frame disable, break, flow control and the busy/empty timing are each driven as directed sequences.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even_sel;
    logic       stick;
    logic       two_stop;
  } frame_fmt_t;

  // Index of the last data bit: code 0 -> bit 4 (5 bits) ... code 3 -> bit 7.
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction

  // Keeps only the data bits the word-length code selects.
  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  // Parity bit value for one character under a given format.
  function automatic logic parity_of(input logic [CHAR_W-1:0] d, input frame_fmt_t f);
    if (f.stick) return ~f.even_sel;
    return (^(d & char_mask(f.wlen))) ^ ~f.even_sel;
  endfunction

endpackage

// File: rtl/async_tx_buffer.sv
module async_tx_buffer #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    count;
  logic [CW-1:0]    cap;
  logic             push, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap    = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign full   = (count >= cap);
  assign empty  = (count == '0);
  assign push   = wr_valid && !full;
  assign pop_ok = pop && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)   wp <= ptr_next(wp);
      if (pop_ok) rp <= ptr_next(rp);
      case ({push, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !pop) |=> (count == $past(count)));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/async_tx_serializer.sv
module async_tx_serializer
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_enable,
  input  logic              send_break,
  input  logic              cts_flow_en,
  input  logic              cts,
  input  frame_fmt_t        fmt,
  input  logic              buf_empty,
  input  logic [CHAR_W-1:0] buf_data,
  output logic              pop,
  output logic              start_evt,
  output logic              frame_active,
  output logic              txd
);

  tx_state_e         st;
  logic [CHAR_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              lat_par_en, lat_par, lat_two;
  logic              may_start, at_last_stop;

  assign may_start    = tx_enable && !send_break && !buf_empty && (!cts_flow_en || cts);
  assign at_last_stop = (st == ST_STOP2) || ((st == ST_STOP1) && !lat_two);
  assign start_evt    = baud_tick && may_start && ((st == ST_IDLE) || at_last_stop);
  assign pop          = start_evt;
  assign frame_active = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      lat_par_en <= 1'b0;
      lat_par    <= 1'b0;
      lat_two    <= 1'b0;
    end else if (baud_tick) begin
      if (start_evt) begin
        st         <= ST_START;
        shreg      <= buf_data;
        bitcnt     <= last_bit_idx(fmt.wlen);
        lat_par_en <= fmt.par_en;
        lat_par    <= parity_of(buf_data, fmt);
        lat_two    <= fmt.two_stop;
      end else begin
        case (st)
          ST_START: st <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bitcnt == 3'd0) st <= lat_par_en ? ST_PAR : ST_STOP1;
            else                bitcnt <= bitcnt - 3'd1;
          end
          ST_PAR:   st <= ST_STOP1;
          ST_STOP1: st <= lat_two ? ST_STOP2 : ST_IDLE;
          ST_STOP2: st <= ST_IDLE;
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_IDLE:  txd = ~send_break;
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = lat_par;
      default:  txd = 1'b1;
    endcase
  end

  // R2
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> baud_tick);

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && frame_active) |=> $stable(txd));

  // R7
  no_start_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !send_break);

  // R8
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> tx_enable);

  // R11
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cts_flow_en) |-> cts);

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        fifo_mode,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        even_sel,
  input  logic        stick_par,
  input  logic        two_stop,
  input  logic        send_break,
  input  logic        tx_enable,
  input  logic        cts_flow_en,
  input  logic        cts,
  input  logic        baud_tick,
  output logic        txd,
  output logic        busy,
  output logic        buf_empty,
  output logic        buf_full
);

  frame_fmt_t        fmt;
  logic [CHAR_W-1:0] head_data;
  logic              pop, start_evt, frame_active;

  assign fmt = '{wlen: word_len, par_en: par_en, even_sel: even_sel,
                 stick: stick_par, two_stop: two_stop};

  async_tx_buffer #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .pop       (pop),
    .rd_data   (head_data),
    .empty     (buf_empty),
    .full      (buf_full)
  );

  async_tx_serializer u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .tx_enable    (tx_enable),
    .send_break   (send_break),
    .cts_flow_en  (cts_flow_en),
    .cts          (cts),
    .fmt          (fmt),
    .buf_empty    (buf_empty),
    .buf_data     (head_data),
    .pop          (pop),
    .start_evt    (start_evt),
    .frame_active (frame_active),
    .txd          (txd)
  );

  assign busy = frame_active || !buf_empty;

  // R9
  busy_cover_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> busy);

  // R10
  start_takes_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !buf_empty);

endmodule

// File: tb/async_tx_test.sv
module async_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fifo_mode = 1'b1;
  logic [1:0] word_len = 2'b11;
  logic       par_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0, two_stop = 1'b0;
  logic       send_break = 1'b0, tx_enable = 1'b0, cts_flow_en = 1'b0, cts = 1'b0;
  logic       baud_tick = 1'b0;
  logic       txd, busy, buf_empty, buf_full;

  int         checks = 0;
  int         errors = 0;
  longint     cyc = 0;
  int         tdiv = 0;

  async_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .word_len(word_len), .par_en(par_en),
    .even_sel(even_sel), .stick_par(stick_par), .two_stop(two_stop),
    .send_break(send_break), .tx_enable(tx_enable), .cts_flow_en(cts_flow_en),
    .cts(cts), .baud_tick(baud_tick), .txd(txd), .busy(busy),
    .buf_empty(buf_empty), .buf_full(buf_full)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // one-cycle tick every 4 clocks
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv      <= 0;
      baud_tick <= 1'b0;
    end else begin
      tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 3);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_start();
    int g = 0;
    while (txd !== 1'b0 && g < 400) begin @(negedge clk); g++; end
  endtask

  task automatic rx_frame(input int nb, input bit pe, input int ns,
                          output logic [7:0] d, output logic p,
                          output bit stop_ok, output longint t0);
    int g = 0;
    while (txd !== 1'b0 && g < 400) begin @(negedge clk); g++; end
    if (g >= 400) chk(1'b0, "R2 start bit seen", 0, 1);
    t0 = cyc;
    repeat (2) @(negedge clk);
    d = '0;
    for (int i = 0; i < nb; i++) begin repeat (4) @(negedge clk); d[i] = txd; end
    p = 1'b0;
    if (pe) begin repeat (4) @(negedge clk); p = txd; end
    stop_ok = 1'b1;
    for (int i = 0; i < ns; i++) begin
      repeat (4) @(negedge clk);
      if (txd !== 1'b1) stop_ok = 1'b0;
    end
  endtask

  task automatic set_fmt(input int wl, input bit pe, input bit ev, input bit sp, input bit tw);
    word_len = 2'(wl); par_en = pe; even_sel = ev; stick_par = sp; two_stop = tw;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d0, d1;
    logic       p;
    bit         sok, held;
    longint     t0, t1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
    chk(buf_full == 1'b0, "R1 full", buf_full, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep of all frame formats, two back-to-back frames each; cts low and ignored (R11)
    for (int cfg = 0; cfg < 64; cfg++) begin
      int nb, ns, ones0, ones1, exp_len;
      logic [7:0] mask;
      logic ep0, ep1;
      bit pe, ev, sp, tw;
      pe = cfg[2]; ev = cfg[3]; sp = cfg[4]; tw = cfg[5];
      set_fmt(cfg % 4, pe, ev, sp, tw);
      nb   = 5 + (cfg % 4);
      ns   = tw ? 2 : 1;
      mask = 8'((1 << nb) - 1);
      d0   = 8'(cfg * 37 + 11);
      d1   = ~d0;
      ones0 = $countones(d0 & mask);
      ones1 = $countones(d1 & mask);
      ep0  = sp ? !ev : (ev ? 1'(ones0 % 2) : 1'(1 - ones0 % 2));
      ep1  = sp ? !ev : (ev ? 1'(ones1 % 2) : 1'(1 - ones1 % 2));
      exp_len = 4 * (1 + nb + (pe ? 1 : 0) + ns);
      put(d0);
      put(d1);
      tx_enable = 1'b1;
      rx_frame(nb, pe, ns, d, p, sok, t0);
      chk(d == (d0 & mask), "R3 data width frame0", d, d0 & mask);
      if (pe) chk(p == ep0, sp ? "R5 stick parity" : "R4 parity", p, ep0);
      chk(sok, "R6 stop bits high", sok, 1);
      rx_frame(nb, pe, ns, d, p, sok, t1);
      chk(d == (d1 & mask), "R2 data lsb first frame1", d, d1 & mask);
      if (pe) chk(p == ep1, sp ? "R5 stick parity" : "R4 parity", p, ep1);
      chk(t1 - t0 == exp_len, tw ? "R6 frame length two stops" : "R2 frame length",
          t1 - t0, exp_len);
      chk(busy == 1'b1, "R9 busy during last stop", busy, 1);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R9 busy after last stop", busy, 0);
      tx_enable = 1'b0;
      wait_idle();
    end

    // Disable mid-frame (R8), busy while disabled (R9), empty flag (R10)
    set_fmt(3, 0, 0, 0, 0);
    put(8'hC3);
    chk(busy == 1'b1, "R9 busy rises while disabled", busy, 1);
    chk(buf_empty == 1'b0, "R10 empty clears on write", buf_empty, 0);
    put(8'h5A);
    held = 1'b1;
    repeat (12) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R8 no frame while disabled", held, 1);
    tx_enable = 1'b1;
    fork
      rx_frame(8, 0, 1, d, p, sok, t0);
      begin
        wait_start();
        repeat (6) @(negedge clk);
        tx_enable = 1'b0;
        chk(buf_empty == 1'b0, "R10 second char still queued", buf_empty, 0);
      end
    join
    chk(d == 8'hC3, "R8 frame completes after disable", d, 8'hC3);
    chk(sok, "R8 stop bit after disable", sok, 1);
    held = 1'b1;
    repeat (16) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R8 no new frame after disable", held, 1);
    chk(busy == 1'b1, "R9 busy with queued char", busy, 1);
    tx_enable = 1'b1;
    fork
      rx_frame(8, 0, 1, d, p, sok, t0);
      begin
        wait_start();
        @(negedge clk);
        chk(buf_empty == 1'b1, "R10 empty once last char starts", buf_empty, 1);
        chk(busy == 1'b1, "R10 busy while shifting", busy, 1);
      end
    join
    chk(d == 8'h5A, "R8 resumed frame", d, 8'h5A);
    chk(busy == 1'b1, "R9 busy in final stop", busy, 1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R9 busy drops", busy, 0);
    tx_enable = 1'b0;

    // Break (R7)
    put(8'h3C);
    tx_enable = 1'b1;
    fork
      rx_frame(8, 0, 1, d, p, sok, t0);
      begin
        wait_start();
        repeat (3) @(negedge clk);
        send_break = 1'b1;
      end
    join
    chk(d == 8'h3C, "R7 current frame completes", d, 8'h3C);
    chk(sok, "R7 stop bit before break", sok, 1);
    repeat (4) @(negedge clk);
    put(8'h55);
    held = 1'b1;
    repeat (24) begin @(negedge clk); if (txd !== 1'b0) held = 1'b0; end
    chk(held, "R7 line held low", held, 1);
    send_break = 1'b0;
    #1;
    chk(txd == 1'b1, "R7 release returns high", txd, 1);
    rx_frame(8, 0, 1, d, p, sok, t0);
    chk(d == 8'h55, "R7 queued char after release", d, 8'h55);
    tx_enable = 1'b0;
    wait_idle();

    // CTS flow control (R11)
    cts_flow_en = 1'b1;
    cts = 1'b0;
    put(8'h96);
    tx_enable = 1'b1;
    held = 1'b1;
    repeat (24) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R11 no start without cts", held, 1);
    chk(busy == 1'b1, "R11 char waits", busy, 1);
    cts = 1'b1;
    rx_frame(8, 0, 1, d, p, sok, t0);
    chk(d == 8'h96, "R11 start with cts", d, 8'h96);
    tx_enable = 1'b0;
    cts_flow_en = 1'b0;
    cts = 1'b0;
    wait_idle();

    // Single holding register (R12)
    fifo_mode = 1'b0;
    put(8'hA1);
    chk(buf_full == 1'b1, "R12 char mode full at 1", buf_full, 1);
    put(8'hB2);
    tx_enable = 1'b1;
    rx_frame(8, 0, 1, d, p, sok, t0);
    chk(d == 8'hA1, "R12 char mode data", d, 8'hA1);
    held = 1'b1;
    repeat (24) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R12 dropped write not sent", held, 1);
    chk(buf_empty == 1'b1, "R12 char mode empty", buf_empty, 1);
    tx_enable = 1'b0;
    fifo_mode = 1'b1;

    // Sixteen-entry queue (R12)
    for (int i = 0; i < 16; i++) begin
      chk(buf_full == 1'b0, "R12 not full below depth", buf_full, 0);
      put(8'(i * 17 + 3));
    end
    chk(buf_full == 1'b1, "R12 full at 16", buf_full, 1);
    put(8'hEE);
    tx_enable = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rx_frame(8, 0, 1, d, p, sok, t0);
      chk(d == 8'(i * 17 + 3), "R12 queue order", d, 8'(i * 17 + 3));
    end
    held = 1'b1;
    repeat (24) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R12 seventeenth write dropped", held, 1);
    chk(busy == 1'b0, "R9 idle after queue drains", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule